// File: doc/BRIEF.md
# One-Shot Bus Configuration Capture

This block fixes the host bus personality of a serial controller once per reset. Before the controller's first configuration write, it records whether the address strobe has toggled at all. At the moment of that write, it samples the channel-select address line and stores the written byte in a register that then locks. Only a reset unlocks it again.

Several fixed settings come from that one event:

- bus mode, multiplexed or not;
- handshake style of the wait/ready pin;
- the internal register address decode, shifted left or right;
- the interrupt acknowledge style, plus a latch for the status acknowledge level;
- the byte lane taken from a 16-bit bus when DMA reads data from memory, with an optional swap.

The surrounding bus logic reads these outputs continuously. Acknowledge pulse generation and the serial channels live elsewhere.

Top module: `bus_cfg_capture`

## Requirements
- R1: A synchronous active-high reset makes `cfg_pending_o` 1 and makes `cfg_o`, `mux_mode_o`, `wait_mode_o` and `ack_lat_o` 0.
- R2: The configuration write is the first cycle after reset with `wr_i`=1 and `dma_sel_i`=0. From the next cycle on, `cfg_pending_o` is 0, and no later write changes `cfg_o`, `mux_mode_o` or `wait_mode_o` until reset.
- R3: A write with `dma_sel_i`=1 while configuration is pending is ignored, and `cfg_pending_o` stays 1.
- R4: `mux_mode_o` becomes 1 if `as_i` was high in any cycle after reset and before the configuration write cycle. Otherwise it becomes 0. A strobe in the write cycle itself does not count.
- R5: `wait_mode_o` takes the value of `chan_sel_i` in the configuration write cycle: 1 means wait-style and 0 means ready-style handshake.
- R6: Byte bits 5:3 are stored as zero. The other bits are stored as written.
- R7: `reg_addr_o` is `ad_i[5:1]` when in multiplexed mode with cfg bit 0 = 1 (shift left). It is `ad_i[4:0]` when cfg bit 0 = 0 or when in non-multiplexed mode.
- R8: Cfg bits 2:1 select the acknowledge type: 00 status, 01 single pulse, 10 reserved, 11 double pulse. `ack_type_o` repeats the code, except that 10 gives `ack_err_o`=1 and `ack_type_o`=00.
- R9: While the block is locked and the effective type is status, `ack_lat_o` loads `intack_i`. In multiplexed mode this happens on a cycle where `as_i` rises. In non-multiplexed mode it happens on a cycle where `ds_i` falls. In all other cases `ack_lat_o` holds its value.
- R10: `dma_byte_o` is `dma_bus_i[7:0]` unless both `dma_rd_i`=1 and cfg bit 7 = 1. In that case it is `dma_bus_i[15:8]` when `dma_a0_i` equals cfg bit 6, and `dma_bus_i[7:0]` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| wr_i | input | 1 | one-cycle write access |
| dma_sel_i | input | 1 | access targets the DMA section |
| chan_sel_i | input | 1 | channel-select address line |
| wdata_i | input | 8 | written byte |
| as_i | input | 1 | address strobe level |
| ds_i | input | 1 | read/data strobe level |
| intack_i | input | 1 | interrupt acknowledge level |
| ad_i | input | 6 | low address/data bits |
| dma_rd_i | input | 1 | memory-to-device DMA read as bus master |
| dma_a0_i | input | 1 | DMA address bit 0 |
| dma_bus_i | input | 16 | DMA data bus |
| cfg_pending_o | output | 1 | configuration not yet written |
| mux_mode_o | output | 1 | multiplexed bus mode |
| wait_mode_o | output | 1 | 1 wait-style, 0 ready-style handshake |
| cfg_o | output | 8 | stored configuration byte |
| reg_addr_o | output | 5 | decoded internal register address |
| ack_type_o | output | 2 | effective acknowledge type |
| ack_err_o | output | 1 | reserved acknowledge code stored |
| ack_lat_o | output | 1 | latched status acknowledge |
| dma_byte_o | output | 8 | selected DMA byte |

## Verification
The hardest situations to reach are the ones around the single capture window. These include a strobe in the very cycle of the configuration write, a DMA-selected write that comes before the real one, and later writes that must all bounce off the locked register. The stimulus therefore resets several times and steers the cycles before capture by hand. It then runs random traffic after capture, with random writes mixed in, so every acknowledge type and every swap and shift setting is tried against edges on both strobes.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;
    localparam int CFG_W      = 8;
    localparam int B_SHIFT    = 0;
    localparam int B_ACK_LO   = 1;
    localparam int B_SWAP_SEL = 6;
    localparam int B_SWAP_EN  = 7;
    localparam logic [CFG_W-1:0] KEEP_MASK = 8'b1100_0111;

    typedef enum logic [1:0] {
        ACK_STATUS = 2'b00,
        ACK_SINGLE = 2'b01,
        ACK_RSVD   = 2'b10,
        ACK_DOUBLE = 2'b11
    } ack_kind_e;

    typedef struct packed {
        logic             lock;
        logic             seen;
        logic             mux;
        logic             wait_h;
        logic [CFG_W-1:0] cfg;
    } cap_state_t;

    typedef struct packed {
        logic as_p;
        logic ds_p;
        logic lat;
    } ack_state_t;
endpackage

// File: rtl/bcfg_capture.sv
module bcfg_capture
    import bcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic             dma_sel_i,
    input  logic             chan_sel_i,
    input  logic             as_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic             locked_o,
    output logic             mux_o,
    output logic             wait_o,
    output logic [CFG_W-1:0] cfg_o
);
    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.lock) begin
            if (wr_i && !dma_sel_i) begin
                st_d.lock   = 1'b1;
                st_d.mux    = st_q.seen;
                st_d.wait_h = chan_sel_i;
                st_d.cfg    = wdata_i & KEEP_MASK;
            end else if (as_i) begin
                st_d.seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign locked_o = st_q.lock;
    assign mux_o    = st_q.mux;
    assign wait_o   = st_q.wait_h;
    assign cfg_o    = st_q.cfg;

    // R2: once locked, the stored settings never move
    a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        st_q.lock |=> (st_q.lock && $stable(st_q.cfg) && $stable(st_q.mux) && $stable(st_q.wait_h)));

    // R3: a DMA-selected write does not lock the register
    a_r3_dma_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (!st_q.lock && wr_i && dma_sel_i) |=> !st_q.lock);
endmodule

// File: rtl/bcfg_addr_dec.sv
module bcfg_addr_dec #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W:0]   ad_i,
    input  logic              mux_i,
    input  logic              shift_left_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_comb begin
        if (mux_i && shift_left_i) addr_o = ad_i[ADDR_W:1];
        else                       addr_o = ad_i[ADDR_W-1:0];
    end
endmodule

// File: rtl/bcfg_ack_ctl.sv
module bcfg_ack_ctl
    import bcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       locked_i,
    input  logic       mux_i,
    input  logic [1:0] code_i,
    input  logic       as_i,
    input  logic       ds_i,
    input  logic       intack_i,
    output logic [1:0] type_o,
    output logic       err_o,
    output logic       lat_o
);
    ack_state_t s_d, s_q;
    ack_kind_e  kind;
    logic       is_status;
    logic       hit;

    always_comb begin
        kind      = ack_kind_e'(code_i);
        err_o     = (kind == ACK_RSVD);
        type_o    = err_o ? ACK_STATUS : kind;
        is_status = (type_o == ACK_STATUS);
        hit       = mux_i ? (as_i && !s_q.as_p) : (!ds_i && s_q.ds_p);
        s_d       = s_q;
        s_d.as_p  = as_i;
        s_d.ds_p  = ds_i;
        if (locked_i && is_status && hit) s_d.lat = intack_i;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign lat_o = s_q.lat;

    // R9: nothing is latched before configuration
    a_r9_lat_idle: assert property (@(posedge clk) disable iff (rst)
        !locked_i |=> !s_q.lat);

    // R9: a non-status type keeps the latch still
    a_r9_lat_hold: assert property (@(posedge clk) disable iff (rst)
        (locked_i && (code_i == 2'b01 || code_i == 2'b11)) |=> $stable(s_q.lat));
endmodule

// File: rtl/bcfg_dma_lane.sv
module bcfg_dma_lane #(
    parameter int BUS_W = 16
) (
    input  logic               rd_i,
    input  logic               a0_i,
    input  logic               swap_en_i,
    input  logic               swap_sel_i,
    input  logic [BUS_W-1:0]   bus_i,
    output logic [BUS_W/2-1:0] byte_o
);
    localparam int LANE = BUS_W / 2;
    logic take_upper;

    always_comb begin
        take_upper = rd_i && swap_en_i && (a0_i == swap_sel_i);
        byte_o     = take_upper ? bus_i[BUS_W-1:LANE] : bus_i[LANE-1:0];
    end
endmodule

// File: rtl/bus_cfg_capture.sv
module bus_cfg_capture
    import bcfg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int BUS_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_i,
    input  logic               dma_sel_i,
    input  logic               chan_sel_i,
    input  logic [CFG_W-1:0]   wdata_i,
    input  logic               as_i,
    input  logic               ds_i,
    input  logic               intack_i,
    input  logic [ADDR_W:0]    ad_i,
    input  logic               dma_rd_i,
    input  logic               dma_a0_i,
    input  logic [BUS_W-1:0]   dma_bus_i,
    output logic               cfg_pending_o,
    output logic               mux_mode_o,
    output logic               wait_mode_o,
    output logic [CFG_W-1:0]   cfg_o,
    output logic [ADDR_W-1:0]  reg_addr_o,
    output logic [1:0]         ack_type_o,
    output logic               ack_err_o,
    output logic               ack_lat_o,
    output logic [BUS_W/2-1:0] dma_byte_o
);
    logic             locked;
    logic             mux;
    logic [CFG_W-1:0] cfg;

    bcfg_capture u_cap (
        .clk(clk), .rst(rst), .wr_i(wr_i), .dma_sel_i(dma_sel_i),
        .chan_sel_i(chan_sel_i), .as_i(as_i), .wdata_i(wdata_i),
        .locked_o(locked), .mux_o(mux), .wait_o(wait_mode_o), .cfg_o(cfg)
    );

    bcfg_addr_dec #(.ADDR_W(ADDR_W)) u_addr (
        .ad_i(ad_i), .mux_i(mux), .shift_left_i(cfg[B_SHIFT]), .addr_o(reg_addr_o)
    );

    bcfg_ack_ctl u_ack (
        .clk(clk), .rst(rst), .locked_i(locked), .mux_i(mux),
        .code_i(cfg[B_ACK_LO+1:B_ACK_LO]), .as_i(as_i), .ds_i(ds_i),
        .intack_i(intack_i), .type_o(ack_type_o), .err_o(ack_err_o), .lat_o(ack_lat_o)
    );

    bcfg_dma_lane #(.BUS_W(BUS_W)) u_lane (
        .rd_i(dma_rd_i), .a0_i(dma_a0_i), .swap_en_i(cfg[B_SWAP_EN]),
        .swap_sel_i(cfg[B_SWAP_SEL]), .bus_i(dma_bus_i), .byte_o(dma_byte_o)
    );

    assign cfg_pending_o = !locked;
    assign mux_mode_o    = mux;
    assign cfg_o         = cfg;
endmodule

// File: tb/bus_cfg_capture_test.sv
module bus_cfg_capture_test;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr = 0, dsel = 0, chan = 0, as_s = 0, ds_s = 0, intack = 0, drd = 0, a0 = 0;
    logic [7:0]  wdata = 0;
    logic [5:0]  ad = 0;
    logic [15:0] bus = 0;
    logic pend, muxo, waito, err, lat;
    logic [7:0] cfgo, dbyte;
    logic [4:0] raddr;
    logic [1:0] atype;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_lock, m_seen, m_mux, m_wait, m_asp, m_dsp, m_lat;
    int m_cfg;

    always #(PERIOD/2) clk = ~clk;

    bus_cfg_capture uut (
        .clk(clk), .rst(rst), .wr_i(wr), .dma_sel_i(dsel), .chan_sel_i(chan),
        .wdata_i(wdata), .as_i(as_s), .ds_i(ds_s), .intack_i(intack), .ad_i(ad),
        .dma_rd_i(drd), .dma_a0_i(a0), .dma_bus_i(bus),
        .cfg_pending_o(pend), .mux_mode_o(muxo), .wait_mode_o(waito), .cfg_o(cfgo),
        .reg_addr_o(raddr), .ack_type_o(atype), .ack_err_o(err), .ack_lat_o(lat),
        .dma_byte_o(dbyte)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int code, eff, sh, up;
        code = (m_cfg >> 1) & 3;
        eff  = (code == 2) ? 0 : code;
        sh   = (m_mux && (m_cfg % 2 == 1)) ? 1 : 0;
        up   = (drd && (m_cfg >= 128) && (a0 == ((m_cfg >> 6) & 1))) ? 1 : 0;
        chk("R1/R2 pending", pend, !m_lock);
        chk("R2/R6 cfg", cfgo, m_cfg);
        chk("R4 mux", muxo, m_mux);
        chk("R5 wait", waito, m_wait);
        chk("R7 addr", raddr, (ad >> sh) % 32);
        chk("R8 type", atype, eff);
        chk("R8 err", err, code == 2);
        chk("R9 lat", lat, m_lat);
        chk("R10 byte", dbyte, up ? (bus / 256) : (bus % 256));
    endtask

    task automatic cyc();
        #1;
        compare_all();
        @(posedge clk);
        if (rst) begin
            m_lock = 0; m_seen = 0; m_mux = 0; m_wait = 0;
            m_asp = 0; m_dsp = 0; m_lat = 0; m_cfg = 0;
        end else begin
            if (m_lock && (((m_cfg >> 1) & 3) % 2 == 0)) begin
                if (m_mux ? (as_s && !m_asp) : (!ds_s && m_dsp)) m_lat = intack;
            end
            m_asp = as_s;
            m_dsp = ds_s;
            if (!m_lock) begin
                if (wr && !dsel) begin
                    m_lock = 1; m_mux = m_seen; m_wait = chan;
                    m_cfg = wdata & 8'hC7;
                end else if (as_s) m_seen = 1;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();
        wr = 0; dsel = 0; as_s = 0;
    endtask

    task automatic do_reset();
        rst = 1; idle();
        cyc(); cyc();
        rst = 0;
        chk("R1 pending after reset", pend, 1);
        chk("R1 cfg after reset", cfgo, 0);
        chk("R1 lat after reset", lat, 0);
    endtask

    task automatic cfg_write(input logic [7:0] v, input logic c, input logic strobe);
        wr = 1; dsel = 0; wdata = v; chan = c; as_s = strobe;
        cyc();
        idle();
    endtask

    task automatic run_rand(input int n);
        for (int i = 0; i < n; i++) begin
            ad = 6'($urandom); bus = 16'($urandom);
            a0 = 1'($urandom); drd = 1'($urandom);
            intack = 1'($urandom); as_s = 1'($urandom); ds_s = 1'($urandom);
            wr = ($urandom % 4 == 0); dsel = 1'($urandom);
            wdata = 8'($urandom); chan = 1'($urandom);
            cyc();
        end
        idle();
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // case A: DMA write first (R3), strobe seen (R4), wait mode (R5), reserved bits (R6)
        do_reset();
        cyc();
        wr = 1; dsel = 1; wdata = 8'h55; cyc(); idle();
        chk("R3 dma write ignored", pend, 1);
        chk("R3 cfg untouched", cfgo, 0);
        as_s = 1; cyc(); idle(); cyc();
        cfg_write(8'hFF, 1'b1, 1'b0);
        chk("R6 reserved zero", cfgo, 8'hC7);
        chk("R4 mux after strobe", muxo, 1);
        chk("R5 wait style", waito, 1);
        run_rand(400);
        chk("R2 locked after writes", cfgo, 8'hC7);

        // case B: no strobe, reserved ack code, non-multiplexed latch on ds fall
        do_reset();
        cyc(); cyc();
        cfg_write(8'h04, 1'b0, 1'b0);
        chk("R4 non-mux", muxo, 0);
        chk("R8 reserved flags err", err, 1);
        chk("R5 ready style", waito, 0);
        run_rand(400);

        // case C: multiplexed, shift left, swap select 0, status ack on as rise
        do_reset();
        as_s = 1; cyc(); idle();
        cfg_write(8'h81, 1'b0, 1'b0);
        run_rand(400);

        // case D: multiplexed, single pulse, swap select 1
        do_reset();
        as_s = 1; cyc(); idle();
        cfg_write(8'hC3, 1'b1, 1'b0);
        run_rand(400);

        // case E: strobe only in the write cycle does not count (R4)
        do_reset();
        cfg_write(8'h79, 1'b1, 1'b1);
        chk("R4 strobe in write cycle ignored", muxo, 0);
        run_rand(400);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule